// File: doc/BRIEF.md
# Matched-Entry Address Translation and Permission Check

This block takes one translation entry that a lookup has already matched and turns it into a result for a single memory access. The entry arrives as a page-size field, a slot index and two page-frame words, one for the even page of the pair and one for the odd page. The access arrives as a virtual address, an access kind, the current privilege level and a flag that says whether the core runs in 32-bit or 64-bit mode.

The block picks one frame word from the pair. It then runs a fixed chain of fault checks. If no check fails, it returns the physical address and the read, write and execute permissions. If a check fails, it returns a fault code.

The logic between input and output is combinational. A single register stage follows it, so each request produces exactly one response on the next clock.

Frame word layout (width `ADDR_W`):

| Bits | Meaning |
|---|---|
| [0] | valid |
| [1] | dirty |
| [3:2] | entry privilege level |
| [4] | strict-privilege |
| [5] | no-read |
| [6] | no-execute |
| [ADDR_W-1:12] | page number |

Access kind encoding: 0 is fetch, 1 is load, 2 is store. The value 3 is treated as a load.

Top module: `tlb_xlate_check`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. After reset, all outputs are zero.
- R2: An entry whose `ent_index` is greater than or equal to `STLB_SIZE` (default 2048) uses its own `ent_ps` as the page size. An entry below that index uses `glb_ps`.
- R3: Virtual address bit [ps] selects the frame word. The value 0 selects `ent_even` and the value 1 selects `ent_odd`.
- R4: A selected word with valid bit 0 gives code 1. This check outranks every other fault.
- R5: A fetch (kind 0) from a word with no-execute set gives code 2. Otherwise, a load (kind 1 or 3) from a word with no-read set gives code 3.
- R6: A privilege fault gives code 4. It is checked after R5 and before R7. With strict-privilege 0, the fault occurs when `req_plv` is numerically greater than the entry level. With strict-privilege 1, the fault occurs whenever `req_plv` differs from the entry level.
- R7: A store (kind 2) to a word whose dirty bit is 0 gives code 5. This is the lowest-priority fault. When no fault occurs, the code is 0.
- R8: On code 0, the physical address is the page number, with its bits [ps-13:0] cleared, shifted left by 12, ORed with virtual address bits [ps-1:0].
- R9: On code 0, read permission is 1, write permission equals the dirty bit and execute permission equals the inverse of no-execute. On any fault, the address and all three permissions are 0.
- R10: In 32-bit mode (`req_wide` = 0), no-execute, no-read and strict-privilege read as 0. In that mode only page-number bits [31:12] of the word are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | ADDR_W | Virtual address |
| req_acc | input | 2 | Access kind |
| req_plv | input | 2 | Current privilege level |
| req_wide | input | 1 | 1 = 64-bit mode |
| ent_index | input | IDX_W | Slot index of the matched entry |
| ent_ps | input | PS_W | Page size stored in the entry |
| glb_ps | input | PS_W | Global page size for the low bank |
| ent_even | input | ADDR_W | Even-page frame word |
| ent_odd | input | ADDR_W | Odd-page frame word |
| rsp_valid | output | 1 | Response strobe |
| rsp_code | output | 3 | Result code |
| rsp_paddr | output | ADDR_W | Physical address |
| rsp_r | output | 1 | Read permission |
| rsp_w | output | 1 | Write permission |
| rsp_x | output | 1 | Execute permission |

## Verification
The bench targets the bank boundary at index 2047 against 2048, where the two banks use different page sizes. A design that compared with the wrong sense would select the wrong half of the pair and build a different address.

It also builds words in which several faults hold at once, for example invalid together with no-execute, or a privilege fault together with non-dirty. A wrong priority order shows up as the wrong code.

Strict-privilege words are run with a current level below the entry level. A design that applied the ordinary greater-than rule would pass these, where the strict rule must fault.

Page numbers whose low bits are set exercise the software-bit clearing, which a broken design would leak into the address. 32-bit requests carry flag bits and page-number bits above bit 31, which a broken design would honour.

// File: rtl/tlb_xlate_check.sv
module tlb_xlate_check #(
  parameter int ADDR_W    = 48,
  parameter int IDX_W     = 12,
  parameter int STLB_SIZE = 2048,
  parameter int PS_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic [1:0]        req_plv,
  input  logic              req_wide,
  input  logic [IDX_W-1:0]  ent_index,
  input  logic [PS_W-1:0]   ent_ps,
  input  logic [PS_W-1:0]   glb_ps,
  input  logic [ADDR_W-1:0] ent_even,
  input  logic [ADDR_W-1:0] ent_odd,
  output logic              rsp_valid,
  output logic [2:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_r,
  output logic              rsp_w,
  output logic              rsp_x
);
  localparam int PN_W = ADDR_W - 12;
  localparam logic [PN_W-1:0] NARROW_PN = {{(PN_W-20){1'b0}}, {20{1'b1}}};

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd2;

  localparam logic [2:0] C_OK    = 3'd0;
  localparam logic [2:0] C_INVAL = 3'd1;
  localparam logic [2:0] C_XI    = 3'd2;
  localparam logic [2:0] C_RI    = 3'd3;
  localparam logic [2:0] C_PRIV  = 3'd4;
  localparam logic [2:0] C_DIRTY = 3'd5;

  logic              own_ps;
  logic [PS_W-1:0]   ps;
  logic [PS_W-1:0]   sw_sh;
  logic [ADDR_W-1:0] word;
  logic              f_v, f_d, f_strict, f_nr, f_nx, priv_bad;
  logic [1:0]        f_lvl;
  logic [PN_W-1:0]   pn_lim, pn;
  logic [ADDR_W-1:0] off_mask, pa;
  logic [2:0]        code;

  assign own_ps = {1'b0, ent_index} >= (IDX_W+1)'(STLB_SIZE);
  assign ps     = own_ps ? ent_ps : glb_ps;
  assign word   = req_vaddr[ps] ? ent_odd : ent_even;

  assign f_v      = word[0];
  assign f_d      = word[1];
  assign f_lvl    = word[3:2];
  assign f_strict = req_wide & word[4];
  assign f_nr     = req_wide & word[5];
  assign f_nx     = req_wide & word[6];

  assign priv_bad = f_strict ? (req_plv != f_lvl) : (req_plv > f_lvl);

  assign pn_lim   = req_wide ? word[ADDR_W-1:12] : (word[ADDR_W-1:12] & NARROW_PN);
  assign sw_sh    = (ps > PS_W'(12)) ? ps - PS_W'(12) : '0;
  assign pn       = pn_lim & ({PN_W{1'b1}} << sw_sh);
  assign off_mask = ~({ADDR_W{1'b1}} << ps);
  assign pa       = {pn, 12'b0} | (req_vaddr & off_mask);

  always_comb begin
    code = C_OK;
    if (!f_v)                                              code = C_INVAL;
    else if (req_acc == ACC_FETCH && f_nx)                 code = C_XI;
    else if (req_acc != ACC_FETCH && req_acc != ACC_STORE && f_nr) code = C_RI;
    else if (priv_bad)                                     code = C_PRIV;
    else if (req_acc == ACC_STORE && !f_d)                 code = C_DIRTY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      rsp_paddr <= '0;
      rsp_r     <= 1'b0;
      rsp_w     <= 1'b0;
      rsp_x     <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code <= code;
        if (code == C_OK) begin
          rsp_paddr <= pa;
          rsp_r     <= 1'b1;
          rsp_w     <= f_d;
          rsp_x     <= ~f_nx;
        end else begin
          rsp_paddr <= '0;
          rsp_r     <= 1'b0;
          rsp_w     <= 1'b0;
          rsp_x     <= 1'b0;
        end
      end
    end
  end
endmodule

module tlb_xlate_check_chk #(
  parameter int ADDR_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic [1:0]        req_acc,
  input logic              rsp_valid,
  input logic [2:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_r,
  input logic              rsp_w,
  input logic              rsp_x
);
  // R1
  resp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid));

  // R7
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code <= 3'd5);

  // R9
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 3'd0) |-> (!rsp_r && !rsp_w && !rsp_x && rsp_paddr == '0));

  // R9
  match_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd0) |-> rsp_r);

  // R7
  store_ok_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd0 && $past(req_acc) == 2'd2) |-> rsp_w);

  // R5
  fetch_ok_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd0 && $past(req_acc) == 2'd0) |-> rsp_x);

  // R8
  page_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 3'd0) |-> rsp_paddr[11:0] == $past(req_vaddr[11:0]));
endmodule

bind tlb_xlate_check tlb_xlate_check_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .req_acc(req_acc), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .rsp_paddr(rsp_paddr), .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x)
);

// File: tb/sim_tlb_xlate_check.sv
`timescale 1ns/1ps
module sim_tlb_xlate_check;
  localparam int AW = 48;

  logic          clk = 0, rst_n = 0;
  logic          req_valid = 0, req_wide = 1;
  logic [AW-1:0] req_vaddr = '0, ent_even = '0, ent_odd = '0;
  logic [1:0]    req_acc = '0, req_plv = '0;
  logic [11:0]   ent_index = '0;
  logic [5:0]    ent_ps = 6'd12, glb_ps = 6'd12;
  logic          rsp_valid, rsp_r, rsp_w, rsp_x;
  logic [2:0]    rsp_code;
  logic [AW-1:0] rsp_paddr;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tlb_xlate_check u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_plv(req_plv), .req_wide(req_wide),
    .ent_index(ent_index), .ent_ps(ent_ps), .glb_ps(glb_ps),
    .ent_even(ent_even), .ent_odd(ent_odd), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .rsp_r(rsp_r),
    .rsp_w(rsp_w), .rsp_x(rsp_x)
  );

  function automatic logic [63:0] wd(input logic v, d, st, nr, nx,
                                     input logic [1:0] lvl, input logic [63:0] pn);
    return (pn << 12) | {57'd0, nx, nr, st, lvl, d, v};
  endfunction

  task automatic model(output logic [2:0] code, output logic [63:0] pa,
                       output logic r, w, x);
    int ps;
    logic [63:0] wv, pn;
    logic nx, nr, st;
    ps  = (ent_index >= 12'd2048) ? int'(ent_ps) : int'(glb_ps);
    wv  = ((req_vaddr >> ps) & 1) ? 64'(ent_odd) : 64'(ent_even);
    nx  = req_wide && wv[6];
    nr  = req_wide && wv[5];
    st  = req_wide && wv[4];
    pn  = (wv >> 12) & ((64'd1 << (AW-12)) - 1);
    if (!req_wide) pn = pn & 64'hFFFFF;
    pn  = (pn >> (ps-12)) << (ps-12);
    code = 0;
    if (!wv[0]) code = 1;
    else if (req_acc == 0 && nx) code = 2;
    else if ((req_acc == 1 || req_acc == 3) && nr) code = 3;
    else if (st ? (req_plv != wv[3:2]) : (req_plv > wv[3:2])) code = 4;
    else if (req_acc == 2 && !wv[1]) code = 5;
    if (code == 0) begin
      pa = (pn << 12) | (64'(req_vaddr) & ((64'd1 << ps) - 1));
      r = 1; w = wv[1]; x = !nx;
    end else begin
      pa = 0; r = 0; w = 0; x = 0;
    end
  endtask

  task automatic apply(input string tag);
    logic [2:0] ec; logic [63:0] ep; logic er, ew, ex;
    string t;
    @(negedge clk);
    req_valid = 1;
    model(ec, ep, er, ew, ex);
    @(negedge clk);
    req_valid = 0;
    t = tag;
    if (t == "") case (ec)
      3'd1: t = "R4"; 3'd2, 3'd3: t = "R5"; 3'd4: t = "R6";
      3'd5: t = "R7"; default: t = "R8";
    endcase
    checks++;
    if (!rsp_valid || rsp_code != ec || 64'(rsp_paddr) != (ep & ((64'd1<<AW)-1))) begin
      fails++;
      $display("FAIL %s: valid=%0b code=%0d pa=%h expected code=%0d pa=%h",
               t, rsp_valid, rsp_code, rsp_paddr, ec, ep);
    end
    checks++;
    if ({rsp_r, rsp_w, rsp_x} != {er, ew, ex}) begin
      fails++;
      $display("FAIL R9: rwx=%b%b%b expected %b%b%b", rsp_r, rsp_w, rsp_x, er, ew, ex);
    end
  endtask

  task automatic setup(input logic [1:0] acc, plv, input logic wide,
                       input logic [11:0] idx, input logic [5:0] eps, gps,
                       input logic [63:0] va, ev, od);
    req_acc = acc; req_plv = plv; req_wide = wide; ent_index = idx;
    ent_ps = eps; glb_ps = gps; req_vaddr = va[AW-1:0];
    ent_even = ev[AW-1:0]; ent_odd = od[AW-1:0];
  endtask

  initial begin
    #20000000;
    fails++;
    $display("FAIL R1: watchdog expired, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid || rsp_code != 0 || rsp_paddr != 0 || rsp_r || rsp_w || rsp_x) begin
      fails++;
      $display("FAIL R1: reset outputs nonzero, actual=%0b/%0d expected=0/0", rsp_valid, rsp_code);
    end
    rst_n = 1;

    // R2: bank boundary, ent_ps=14 vs glb_ps=12, va bit 12 set, bit 14 clear
    setup(1, 0, 1, 12'd2047, 6'd14, 6'd12, 64'h1000, wd(1,1,0,0,0,0,64'hAAAA), wd(1,1,0,0,0,0,64'h5555));
    apply("R2");
    setup(1, 0, 1, 12'd2048, 6'd14, 6'd12, 64'h1000, wd(1,1,0,0,0,0,64'hAAAA), wd(1,1,0,0,0,0,64'h5555));
    apply("R2");
    // R3: odd and even halves
    setup(1, 0, 1, 12'd5, 6'd12, 6'd16, 64'h1_0123, wd(1,0,0,0,0,0,64'h100), wd(1,1,0,0,0,0,64'h200));
    apply("R3");
    setup(1, 0, 1, 12'd5, 6'd12, 6'd16, 64'h0_0123, wd(1,0,0,0,0,0,64'h100), wd(1,1,0,0,0,0,64'h200));
    apply("R3");
    // R4: invalid with every other fault present
    setup(0, 3, 1, 12'd0, 6'd12, 6'd12, 64'h0, wd(0,0,1,1,1,0,64'h7), wd(0,0,1,1,1,0,64'h7));
    apply("R4");
    // R5: fetch from no-exec outranks privilege
    setup(0, 3, 1, 12'd0, 6'd12, 6'd12, 64'h0, wd(1,0,0,1,1,0,64'h7), 64'h0);
    apply("R5");
    setup(1, 3, 1, 12'd0, 6'd12, 6'd12, 64'h0, wd(1,0,0,1,1,0,64'h7), 64'h0);
    apply("R5");
    // R6: strict mode with lower current level
    setup(1, 1, 1, 12'd0, 6'd12, 6'd12, 64'h0, wd(1,1,1,0,0,2'd3,64'h7), 64'h0);
    apply("R6");
    setup(1, 1, 1, 12'd0, 6'd12, 6'd12, 64'h0, wd(1,1,0,0,0,2'd3,64'h7), 64'h0);
    apply("R6");
    // R7: privilege outranks dirty, then dirty alone
    setup(2, 2, 1, 12'd0, 6'd12, 6'd12, 64'h0, wd(1,0,0,0,0,2'd1,64'h7), 64'h0);
    apply("R7");
    setup(2, 0, 1, 12'd0, 6'd12, 6'd12, 64'h0, wd(1,0,0,0,0,2'd1,64'h7), 64'h0);
    apply("R7");
    // R8: software bits cleared for a 2 MiB page
    setup(1, 0, 1, 12'd3000, 6'd21, 6'd12, 64'h1F_ABCD, wd(1,1,0,0,0,0,64'h1_23FF), wd(1,1,0,0,0,0,64'h1_23FF));
    apply("R8");
    // R10: narrow mode ignores flags and upper page-number bits
    setup(0, 3, 0, 12'd0, 6'd12, 6'd12, 64'h345, wd(1,0,1,1,1,2'd3,64'hF_F123_4567), 64'h0);
    apply("R10");

    for (int i = 0; i < 4000; i++) begin
      logic [63:0] ev, od;
      int ps_e, ps_g;
      ps_e = 12 + int'($urandom % 20);
      ps_g = 12 + int'($urandom % 20);
      ev = {$urandom, $urandom};
      od = {$urandom, $urandom};
      if ($urandom % 4 != 0) begin ev[0] = 1; od[0] = 1; end
      if ($urandom % 2 != 0) begin ev[6:4] = 0; od[6:4] = 0; end
      setup(2'($urandom), 2'($urandom), 1'($urandom % 4 != 0), 12'($urandom),
            6'(ps_e), 6'(ps_g), {$urandom, $urandom}, ev, od);
      apply("");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule